// File: doc/BRIEF.md
# Fractional-N Feedback Ratio Controller

This block produces the division ratio that the feedback divider of a fractional-N synthesizer should apply on each comparison cycle. A programmed integer part (9 bits), fractional part (12 bits) and modulus (12 bits) feed a first-order accumulator. Each time the comparison clock ticks, the accumulator adds the fractional part modulo the modulus, and the block presents either the integer value or the integer value plus one, depending on whether the addition wrapped. Over one modulus period, the average ratio is INT + FRAC/MOD.

The same block divides the reference clock by a programmable 4-bit ratio to produce the comparison tick, a one-cycle enable pulse on the reference clock. The modulus is double buffered. A modulus write only stages the new value. The next write of the integer/fractional pair makes it active and clears the accumulator. Two registered flags report settings that the loop cannot honour: a fractional value above the modulus, and an integer value below the minimum allowed by the selected prescaler. A counter-reset input holds the dividers and the accumulator at rest.

Top module: `fracn_ratio_ctrl`

## Requirements
- R1: While `rst` is high, on the following clock edge `n_out`, `pfd_tick`, `int_err` and `frac_err` go to 0, the staged and active registers clear to 0, and no modulus is staged.
- R2: The reference divider raises `pfd_tick` for one clock out of every `rdiv` clocks; an `rdiv` of 0 acts as 1, giving a tick on every clock.
- R3: On each clock edge where `pfd_tick` is high (and no reset or clear applies), the accumulator adds the effective fractional value. If the sum is greater than or equal to the active modulus, `n_out` becomes INT+1 and the modulus is subtracted; otherwise `n_out` becomes INT and the sum is kept.
- R4: When the active fractional value exceeds the active modulus, the accumulator uses the modulus in its place, and `frac_err` is high one clock later.
- R5: `int_err` is high one clock after the active integer value is below 31 with `presc_sel`=0 (4/5 prescaler), or below 91 with `presc_sel`=1 (8/9 prescaler), and low otherwise.
- R6: A `mod_wr` pulse only stages `mod_val`. The active modulus changes solely on a later `n_wr`, which also loads `int_val` and `frac_val` into the active registers on that same edge.
- R7: On the edge where an `n_wr` activates a staged modulus, the accumulator clears to 0 and no accumulation step takes place on that edge; `n_out` keeps its value.
- R8: While `cnt_rst` is high, the reference counter, `pfd_tick`, the accumulator and `n_out` are held at 0. The programmed registers keep their values.
- R9: If `mod_wr` and `n_wr` occur on the same edge, the `n_wr` activates only a modulus staged earlier (if one exists), and the new `mod_val` remains staged for the next `n_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| int_val | input | 9 | Integer part, loaded on `n_wr` |
| frac_val | input | 12 | Fractional part, loaded on `n_wr` |
| mod_val | input | 12 | Modulus, staged on `mod_wr` |
| mod_wr | input | 1 | Stage `mod_val` |
| n_wr | input | 1 | Load integer/fractional pair and activate staged modulus |
| presc_sel | input | 1 | 0 selects the 4/5 prescaler, 1 selects the 8/9 prescaler |
| rdiv | input | 4 | Reference division ratio (0 acts as 1) |
| cnt_rst | input | 1 | Hold counters and accumulator at rest |
| pfd_tick | output | 1 | Comparison-clock enable pulse |
| n_out | output | 10 | Feedback divide value for the current comparison cycle |
| int_err | output | 1 | Integer value below prescaler minimum |
| frac_err | output | 1 | Fractional value above modulus |

## Verification
A wrong accumulator residue does not show up right away. It changes where the INT+1 cycles fall within the modulus period, so a bench that compares `n_out` on every tick sees the mismatch at the first wrap that lands on the wrong tick, at most one modulus period later. A reference counter that is off by one moves `pfd_tick` within a few clocks. A mishandled staging bit surfaces as a wrap pattern for the wrong modulus after the next `n_wr`. The bench therefore compares all four outputs on every clock against a cycle model, so a divergence is caught on the cycle it first reaches a port.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // Prescaler mode as seen on presc_sel
  typedef enum logic {
    PRESC_4_5 = 1'b0,
    PRESC_8_9 = 1'b1
  } presc_e;

endpackage

// File: rtl/fracn_ref_div.sv
module fracn_ref_div #(
  parameter int RDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_rst,
  input  logic [RDIV_W-1:0] rdiv,
  output logic              tick
);

  logic [RDIV_W-1:0] cnt;
  logic [RDIV_W-1:0] lim;

  // a ratio of zero behaves as one
  always_comb lim = (rdiv == '0) ? RDIV_W'(1) : rdiv;

  always_ff @(posedge clk) begin
    if (rst || cnt_rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim - RDIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + RDIV_W'(1);
      tick <= 1'b0;
    end
  end

  AST_TICK_ALIGN: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt == '0)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    cnt_rst |=> (cnt == '0 && !tick)); // R8

endmodule

// File: rtl/fracn_prog_regs.sv
module fracn_prog_regs
  import fracn_pkg::*;
#(
  parameter int INT_W   = 9,
  parameter int FRAC_W  = 12,
  parameter int NMIN_LO = 31,
  parameter int NMIN_HI = 91
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [FRAC_W-1:0] mod_val,
  input  logic              mod_wr,
  input  logic              n_wr,
  input  logic              presc_sel,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] frac_eff,
  output logic [FRAC_W-1:0] act_mod,
  output logic              mod_activate,
  output logic              int_err,
  output logic              frac_err
);

  localparam logic [INT_W-1:0] MIN_45 = INT_W'(NMIN_LO);
  localparam logic [INT_W-1:0] MIN_89 = INT_W'(NMIN_HI);

  logic [FRAC_W-1:0] act_frac;
  logic [FRAC_W-1:0] pend_mod;
  logic              pend_v;
  logic [INT_W-1:0]  int_floor;
  logic              frac_over;
  presc_e            presc;

  always_comb begin
    presc        = presc_e'(presc_sel);
    int_floor    = (presc == PRESC_8_9) ? MIN_89 : MIN_45;
    frac_over    = act_frac > act_mod;
    frac_eff     = frac_over ? act_mod : act_frac;
    mod_activate = n_wr && pend_v;
  end

  // staging register for the modulus
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mod <= '0;
      pend_v   <= 1'b0;
    end else if (mod_wr) begin
      pend_mod <= mod_val;
      pend_v   <= 1'b1;
    end else if (mod_activate) begin
      pend_v   <= 1'b0;
    end
  end

  // active settings
  always_ff @(posedge clk) begin
    if (rst) begin
      act_int  <= '0;
      act_frac <= '0;
      act_mod  <= '0;
    end else if (n_wr) begin
      act_int  <= int_val;
      act_frac <= frac_val;
      if (pend_v) act_mod <= pend_mod;
    end
  end

  // registered error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      int_err  <= 1'b0;
      frac_err <= 1'b0;
    end else begin
      int_err  <= act_int < int_floor;
      frac_err <= frac_over;
    end
  end

  AST_MOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !n_wr |=> $stable(act_mod)); // R6
  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    mod_wr |=> pend_v); // R9

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_rst,
  input  logic              tick,
  input  logic              clr,
  input  logic [INT_W-1:0]  int_v,
  input  logic [FRAC_W-1:0] frac_v,
  input  logic [FRAC_W-1:0] mod_v,
  output logic [INT_W:0]    n_out
);

  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  wrapped;
  logic              carry;

  always_comb begin
    sum     = {1'b0, acc} + {1'b0, frac_v};
    carry   = sum >= {1'b0, mod_v};
    wrapped = carry ? (sum - {1'b0, mod_v}) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_rst) begin
      acc   <= '0;
      n_out <= '0;
    end else if (clr) begin
      acc   <= '0;
    end else if (tick) begin
      acc   <= wrapped[FRAC_W-1:0];
      n_out <= {1'b0, int_v} + {{INT_W{1'b0}}, carry};
    end
  end

  AST_FRAC_CLAMP: assert property (@(posedge clk) disable iff (rst)
    frac_v <= mod_v); // R4
  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
    (mod_v != '0) |-> (acc < mod_v)); // R3
  AST_N_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !cnt_rst) |=>
      (n_out == {1'b0, $past(int_v)} || n_out == {1'b0, $past(int_v)} + (INT_W+1)'(1))); // R3
  AST_CLR_ACC: assert property (@(posedge clk) disable iff (rst)
    (clr && !cnt_rst) |=> (acc == '0)); // R7

endmodule

// File: rtl/fracn_ratio_ctrl.sv
module fracn_ratio_ctrl #(
  parameter int INT_W   = 9,
  parameter int FRAC_W  = 12,
  parameter int RDIV_W  = 4,
  parameter int NMIN_LO = 31,
  parameter int NMIN_HI = 91
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [FRAC_W-1:0] mod_val,
  input  logic              mod_wr,
  input  logic              n_wr,
  input  logic              presc_sel,
  input  logic [RDIV_W-1:0] rdiv,
  input  logic              cnt_rst,
  output logic              pfd_tick,
  output logic [INT_W:0]    n_out,
  output logic              int_err,
  output logic              frac_err
);

  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] frac_eff;
  logic [FRAC_W-1:0] act_mod;
  logic              mod_activate;

  fracn_ref_div #(.RDIV_W(RDIV_W)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .cnt_rst (cnt_rst),
    .rdiv    (rdiv),
    .tick    (pfd_tick)
  );

  fracn_prog_regs #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .NMIN_LO (NMIN_LO),
    .NMIN_HI (NMIN_HI)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .int_val      (int_val),
    .frac_val     (frac_val),
    .mod_val      (mod_val),
    .mod_wr       (mod_wr),
    .n_wr         (n_wr),
    .presc_sel    (presc_sel),
    .act_int      (act_int),
    .frac_eff     (frac_eff),
    .act_mod      (act_mod),
    .mod_activate (mod_activate),
    .int_err      (int_err),
    .frac_err     (frac_err)
  );

  fracn_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .cnt_rst (cnt_rst),
    .tick    (pfd_tick),
    .clr     (mod_activate),
    .int_v   (act_int),
    .frac_v  (frac_eff),
    .mod_v   (act_mod),
    .n_out   (n_out)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (n_out == '0 && !pfd_tick && !int_err && !frac_err)); // R1
  AST_HOLD_N: assert property (@(posedge clk) disable iff (rst)
    cnt_rst |=> (n_out == '0 && !pfd_tick)); // R8

endmodule

// File: tb/sim_fracn_ratio_ctrl.sv
module sim_fracn_ratio_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  int_val;
  logic [11:0] frac_val, mod_val;
  logic        mod_wr, n_wr, presc_sel, cnt_rst;
  logic [3:0]  rdiv;
  logic        pfd_tick, int_err, frac_err;
  logic [9:0]  n_out;

  int vectors = 0;
  int miss = 0;
  string phase = "R1 reset";

  // reference model state
  int m_cnt, m_tick, m_acc, m_n, m_int, m_frac, m_mod, m_pend, m_pv, m_ierr, m_ferr;

  always #5 clk = ~clk;

  fracn_ratio_ctrl u0 (
    .clk(clk), .rst(rst), .int_val(int_val), .frac_val(frac_val),
    .mod_val(mod_val), .mod_wr(mod_wr), .n_wr(n_wr), .presc_sel(presc_sel),
    .rdiv(rdiv), .cnt_rst(cnt_rst), .pfd_tick(pfd_tick), .n_out(n_out),
    .int_err(int_err), .frac_err(frac_err)
  );

  function automatic int nmin(input logic p);
    return p ? 91 : 31;
  endfunction

  task automatic model_edge();
    int act, feff, sum, lim;
    if (rst) begin
      m_cnt = 0; m_tick = 0; m_acc = 0; m_n = 0; m_int = 0; m_frac = 0;
      m_mod = 0; m_pend = 0; m_pv = 0; m_ierr = 0; m_ferr = 0;
      return;
    end
    act  = (n_wr && m_pv) ? 1 : 0;
    feff = (m_frac > m_mod) ? m_mod : m_frac;
    // accumulator, from old state (R3 R4 R7 R8)
    if (cnt_rst) begin m_acc = 0; m_n = 0; end
    else if (act != 0) m_acc = 0;
    else if (m_tick != 0) begin
      sum = m_acc + feff;
      if (sum >= m_mod) begin m_n = m_int + 1; m_acc = sum - m_mod; end
      else begin m_n = m_int; m_acc = sum; end
    end
    // flags (R4 R5)
    m_ferr = (m_frac > m_mod) ? 1 : 0;
    m_ierr = (m_int < nmin(presc_sel)) ? 1 : 0;
    // reference divider (R2)
    lim = (rdiv == 0) ? 1 : int'(rdiv);
    if (cnt_rst) begin m_cnt = 0; m_tick = 0; end
    else if (m_cnt >= lim - 1) begin m_cnt = 0; m_tick = 1; end
    else begin m_cnt = m_cnt + 1; m_tick = 0; end
    // registers (R6 R9)
    if (n_wr) begin
      m_int = int'(int_val); m_frac = int'(frac_val);
      if (m_pv != 0) m_mod = m_pend;
    end
    if (mod_wr) begin m_pend = int'(mod_val); m_pv = 1; end
    else if (act != 0) m_pv = 0;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miss++;
      $display("FAIL %s [%s] got %0d expected %0d", tag, phase, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 n_out", int'(n_out), m_n);
    chk("R2 pfd_tick", int'(pfd_tick), m_tick);
    chk("R5 int_err", int'(int_err), m_ierr);
    chk("R4 frac_err", int'(frac_err), m_ferr);
    mod_wr = 1'b0;
    n_wr   = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_mod(input int m);
    mod_val = 12'(m); mod_wr = 1'b1; step();
  endtask

  task automatic wr_n(input int i, input int f);
    int_val = 9'(i); frac_val = 12'(f); n_wr = 1'b1; step();
  endtask

  initial begin
    #2000000;
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst = 1'b1; int_val = '0; frac_val = '0; mod_val = '0;
    mod_wr = 1'b0; n_wr = 1'b0; presc_sel = 1'b0; rdiv = 4'd3; cnt_rst = 1'b0;
    @(negedge clk);
    phase = "R1 reset"; run(3);
    rst = 1'b0;

    phase = "R3 basic accumulation, R6 activation";
    presc_sel = 1'b1; wr_mod(10); wr_n(100, 3); run(60);
    phase = "R2 ratio 15"; rdiv = 4'd15; run(50);
    phase = "R2 ratio zero acts as one"; rdiv = 4'd0; run(20);
    phase = "R3 frac equals mod"; wr_n(120, 10); run(15);
    phase = "R4 clamp of frac above mod"; wr_n(120, 25); run(15);
    phase = "R5 4/5 limit"; presc_sel = 1'b0; wr_n(30, 1); run(4); wr_n(31, 1); run(4);
    phase = "R5 8/9 limit"; presc_sel = 1'b1; wr_n(90, 1); run(4); wr_n(91, 1); run(4);
    phase = "R6 staged modulus unused"; rdiv = 4'd2; wr_mod(7); run(30);
    phase = "R7 activation clears accumulator"; wr_n(200, 5); run(30);
    phase = "R8 counter reset hold"; cnt_rst = 1'b1; run(10); cnt_rst = 1'b0; run(20);
    phase = "R9 simultaneous writes";
    mod_val = 12'd13; mod_wr = 1'b1; int_val = 9'd150; frac_val = 12'd4; n_wr = 1'b1; step();
    run(30); wr_n(151, 6); run(40);

    phase = "random R2 R3 R4 R5 R6 R7 R8 R9";
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 4) begin mod_val = 12'($urandom % 4096); mod_wr = 1'b1; end
      if (r >= 4 && r < 5) begin mod_val = 12'($urandom % 8); mod_wr = 1'b1; end
      if (r >= 10 && r < 15) begin
        int_val = 9'($urandom % 512); frac_val = 12'($urandom % 4096); n_wr = 1'b1;
      end
      if (r >= 15 && r < 17) begin
        int_val = 9'(25 + $urandom % 80); frac_val = 12'($urandom % 12); n_wr = 1'b1;
      end
      if (r == 20) cnt_rst = ~cnt_rst;
      if (r == 21) rdiv = 4'($urandom % 16);
      if (r == 22) presc_sel = ~presc_sel;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

endmodule